// File: doc/BRIEF.md
# Buffered-Duty PWM Channel

This block is one pulse-width-modulated output channel. A free-running prescaler divides the input clock by a power of two. A period counter then steps once per divided tick, from zero up to the period minus one, and wraps. The output is asserted while the count is at or above the duty value, so the duty value sets the length of the inactive head of each period. A polarity bit can invert the whole waveform.

When the channel is stopped, software loads the duty and period values straight into the working registers. When it runs, the working values are frozen. A change goes through a buffered update port that targets either duty or period, as the configuration selects. The buffered value is copied into the working register only when the counter wraps, so the waveform never shows a half-changed period. Every wrap produces a one-cycle completion pulse, which tells software that a buffered value has reached the output.

Top module: `pwm_buffered_channel`

## Requirements
- R1: After reset `running`, `pwm_out` and `period_done` are 0, polarity is normal, and the duty and period registers hold 0.
- R2: A pulse on `en_req` starts the channel and a pulse on `dis_req` stops it. `running` shows the state one cycle later. When both arrive in the same cycle, stop wins.
- R3: The period counter advances once every 2^p clocks, where p is the 4-bit `cfg_prescale` value captured by `cfg_wr`. Values 11 to 15 act as 10.
- R4: The counter runs from 0 to period-1 and then wraps to 0. A period of 0 or 1 wraps on every tick.
- R5: Before polarity is applied, `pwm_out` is 1 when the count is at or above duty, and it lags the count by one clock. Duty 0 gives a full-on output, and duty at or above the period gives a full-off output.
- R6: `cfg_invert`=1 inverts `pwm_out`. While the channel is stopped, `pwm_out` equals the polarity bit, which is the inactive level.
- R7: While stopped, `duty_wr` and `period_wr` load the working registers directly. `upd_wr` also loads directly, into the register selected by `cfg_upd_period` (0 = duty, 1 = period).
- R8: While running, `duty_wr` and `period_wr` are ignored.
- R9: While running, `upd_wr` buffers its value for the target selected by `cfg_upd_period`. The buffered value is applied at the next wrap. A write in the wrap cycle itself is applied at that wrap.
- R10: `period_done` is a one-cycle pulse in the clock after every wrap of the counter.
- R11: Stopping the channel clears the counter and discards any buffered update that has not been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Start pulse |
| dis_req | input | 1 | Stop pulse |
| cfg_wr | input | 1 | Capture the configuration fields |
| cfg_prescale | input | 4 | Prescaler exponent |
| cfg_invert | input | 1 | Output polarity inversion |
| cfg_upd_period | input | 1 | Update target: 0 duty, 1 period |
| duty_wr | input | 1 | Direct duty write |
| duty_data | input | 16 | Direct duty value |
| period_wr | input | 1 | Direct period write |
| period_data | input | 16 | Direct period value |
| upd_wr | input | 1 | Buffered update write |
| upd_data | input | 16 | Buffered update value |
| running | output | 1 | Channel running |
| pwm_out | output | 1 | Waveform output |
| period_done | output | 1 | Period-complete pulse |

## Verification
A corrupted counter or prescaler shows up at `pwm_out` within one period as a shifted edge, and at `period_done` as a pulse out of place. A buffered value applied at the wrong moment changes the high time one period early or one period late. An update that survives a stop shows up in the first period after the restart. Comparing against a per-clock reference model therefore catches each of these faults in the first cycle it reaches a port.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int DEF_CNT_W   = 16;
  localparam int DEF_PRE_W   = 4;
  localparam int DEF_PRE_MAX = 10;

  typedef enum logic {
    TGT_DUTY   = 1'b0,
    TGT_PERIOD = 1'b1
  } upd_tgt_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W   = pwm_chan_pkg::DEF_PRE_W,
  parameter int PRE_MAX = pwm_chan_pkg::DEF_PRE_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_sel,
  output logic             tick
);
  logic [PRE_MAX-1:0] div_q;
  logic [PRE_MAX-1:0] mask;

  // Low pre_sel bits of the divider must all be ones for a tick.
  for (genvar i = 0; i < PRE_MAX; i++) begin : g_mask
    assign mask[i] = (int'(pre_sel) > i);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  assign tick = run && ((div_q & mask) == mask);
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
  parameter int CNT_W = pwm_chan_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             stop,
  input  logic             tick,
  input  logic             invert,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             wave,
  output logic             done
);
  logic [CNT_W:0] next_cnt;

  assign next_cnt = {1'b0, count} + 1'b1;
  assign wrap     = tick && (next_cnt >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst || stop)        count <= '0;
    else if (run && tick)   count <= wrap ? '0 : next_cnt[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave <= 1'b0;
      done <= 1'b0;
    end else begin
      wave <= run ? ((count >= duty) ^ invert) : invert;
      done <= wrap;
    end
  end
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             stop,
  input  logic             wrap,
  input  upd_tgt_e         target,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_data,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_data,
  input  logic             upd_wr,
  input  logic [CNT_W-1:0] upd_data,
  output logic [CNT_W-1:0] duty_q,
  output logic [CNT_W-1:0] period_q,
  output logic             pending
);
  logic [CNT_W-1:0] buf_duty, buf_period;
  logic             pend_duty, pend_period;
  logic             upd_duty, upd_period;

  assign upd_duty   = upd_wr && (target == TGT_DUTY);
  assign upd_period = upd_wr && (target == TGT_PERIOD);
  assign pending    = pend_duty || pend_period;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q      <= '0;
      period_q    <= '0;
      buf_duty    <= '0;
      buf_period  <= '0;
      pend_duty   <= 1'b0;
      pend_period <= 1'b0;
    end else if (run) begin
      if (stop) begin
        pend_duty   <= 1'b0;
        pend_period <= 1'b0;
      end else if (wrap) begin
        if (upd_duty)        duty_q   <= upd_data;
        else if (pend_duty)  duty_q   <= buf_duty;
        if (upd_period)      period_q <= upd_data;
        else if (pend_period) period_q <= buf_period;
        pend_duty   <= 1'b0;
        pend_period <= 1'b0;
      end else begin
        if (upd_duty) begin
          buf_duty  <= upd_data;
          pend_duty <= 1'b1;
        end
        if (upd_period) begin
          buf_period  <= upd_data;
          pend_period <= 1'b1;
        end
      end
    end else begin
      if (duty_wr)         duty_q   <= duty_data;
      else if (upd_duty)   duty_q   <= upd_data;
      if (period_wr)       period_q <= period_data;
      else if (upd_period) period_q <= upd_data;
    end
  end
endmodule

// File: rtl/pwm_buffered_channel.sv
module pwm_buffered_channel
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W   = DEF_CNT_W,
  parameter int PRE_W   = DEF_PRE_W,
  parameter int PRE_MAX = DEF_PRE_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_req,
  input  logic             dis_req,
  input  logic             cfg_wr,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic             cfg_invert,
  input  logic             cfg_upd_period,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_data,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_data,
  input  logic             upd_wr,
  input  logic [CNT_W-1:0] upd_data,
  output logic             running,
  output logic             pwm_out,
  output logic             period_done
);
  localparam logic [PRE_W-1:0] PRE_LIMIT = PRE_W'(PRE_MAX);

  logic             run_q;
  logic             pol_q;
  logic [PRE_W-1:0] pre_q;
  upd_tgt_e         tgt_q;
  logic             tick, wrap, pend_w;
  logic [CNT_W-1:0] cnt_w, dty_w, prd_w;
  logic             stop;

  assign stop = run_q && dis_req;

  always_ff @(posedge clk) begin
    if (rst)          run_q <= 1'b0;
    else if (dis_req) run_q <= 1'b0;
    else if (en_req)  run_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= 1'b0;
      pre_q <= '0;
      tgt_q <= TGT_DUTY;
    end else if (cfg_wr) begin
      pol_q <= cfg_invert;
      pre_q <= (cfg_prescale > PRE_LIMIT) ? PRE_LIMIT : cfg_prescale;
      tgt_q <= upd_tgt_e'(cfg_upd_period);
    end
  end

  pwm_tick_gen #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_tick (
    .clk(clk), .rst(rst), .run(run_q), .pre_sel(pre_q), .tick(tick)
  );

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .run(run_q), .stop(stop), .wrap(wrap),
    .target(tgt_q),
    .duty_wr(duty_wr), .duty_data(duty_data),
    .period_wr(period_wr), .period_data(period_data),
    .upd_wr(upd_wr), .upd_data(upd_data),
    .duty_q(dty_w), .period_q(prd_w), .pending(pend_w)
  );

  pwm_period_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(run_q), .stop(stop), .tick(tick),
    .invert(pol_q), .duty(dty_w), .period(prd_w),
    .count(cnt_w), .wrap(wrap), .wave(pwm_out), .done(period_done)
  );

  assign running = run_q;
endmodule

// File: rtl/pwm_chan_checker.sv
module pwm_chan_checker #(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             running,
  input logic             pwm_out,
  input logic             period_done,
  input logic             pol,
  input logic [PRE_W-1:0] pre,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] dty,
  input logic [CNT_W-1:0] prd,
  input logic             pend
);
  a_r3_prescale_clamped: assert property (@(posedge clk) disable iff (rst)
    int'(pre) <= PRE_MAX);

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt == '0 || cnt < prd));

  a_r11_stopped_count_zero: assert property (@(posedge clk) disable iff (rst)
    !running |-> cnt == '0);

  a_r6_stopped_level: assert property (@(posedge clk) disable iff (rst)
    !$past(running) |-> pwm_out == $past(pol));

  a_r10_done_at_wrap: assert property (@(posedge clk) disable iff (rst)
    period_done |-> ($past(running) && cnt == '0));

  a_r9_applied_at_done: assert property (@(posedge clk) disable iff (rst)
    period_done |-> !pend);

  a_r8_frozen_while_running: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running) && !period_done) |-> ($stable(dty) && $stable(prd)));
endmodule

bind pwm_buffered_channel pwm_chan_checker #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_MAX(PRE_MAX)
) u_chk (
  .clk(clk), .rst(rst), .running(running), .pwm_out(pwm_out),
  .period_done(period_done), .pol(pol_q), .pre(pre_q), .cnt(cnt_w),
  .dty(dty_w), .prd(prd_w), .pend(pend_w)
);

// File: tb/pwm_buffered_channel_tb.sv
module pwm_buffered_channel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_req = 0, dis_req = 0, cfg_wr = 0;
  logic [3:0]  cfg_prescale = 0;
  logic        cfg_invert = 0, cfg_upd_period = 0;
  logic        duty_wr = 0, period_wr = 0, upd_wr = 0;
  logic [15:0] duty_data = 0, period_data = 0, upd_data = 0;
  logic        running, pwm_out, period_done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwm_buffered_channel u_dut (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
    .cfg_wr(cfg_wr), .cfg_prescale(cfg_prescale), .cfg_invert(cfg_invert),
    .cfg_upd_period(cfg_upd_period),
    .duty_wr(duty_wr), .duty_data(duty_data),
    .period_wr(period_wr), .period_data(period_data),
    .upd_wr(upd_wr), .upd_data(upd_data),
    .running(running), .pwm_out(pwm_out), .period_done(period_done)
  );

  // Behavioural reference model, stepped on each rising edge.
  int m_run, m_div, m_cnt, m_dty, m_prd, m_pol, m_pre, m_tgt;
  int m_bd, m_bp, m_pd, m_pp, m_out, m_done;
  int t_mask, t_tick, t_wrap;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_div = 0; m_cnt = 0; m_dty = 0; m_prd = 0; m_pol = 0;
      m_pre = 0; m_tgt = 0; m_bd = 0; m_bp = 0; m_pd = 0; m_pp = 0;
      m_out = 0; m_done = 0;
    end else begin
      t_mask = (1 << m_pre) - 1;
      t_tick = (m_run != 0 && ((m_div & t_mask) == t_mask)) ? 1 : 0;
      t_wrap = (t_tick != 0 && (m_cnt + 1 >= m_prd)) ? 1 : 0;
      m_out  = (m_run != 0) ? (((m_cnt >= m_dty) ? 1 : 0) ^ m_pol) : m_pol;
      m_done = t_wrap;
      if (m_run != 0) begin
        if (dis_req) begin
          m_pd = 0; m_pp = 0; m_cnt = 0;
        end else begin
          if (t_tick != 0) m_cnt = (t_wrap != 0) ? 0 : m_cnt + 1;
          if (t_wrap != 0) begin
            if (upd_wr && m_tgt == 0) m_dty = upd_data;
            else if (m_pd != 0)       m_dty = m_bd;
            if (upd_wr && m_tgt == 1) m_prd = upd_data;
            else if (m_pp != 0)       m_prd = m_bp;
            m_pd = 0; m_pp = 0;
          end else if (upd_wr) begin
            if (m_tgt == 0) begin m_bd = upd_data; m_pd = 1; end
            else            begin m_bp = upd_data; m_pp = 1; end
          end
        end
        m_div = (m_div + 1) % 1024;
      end else begin
        m_div = 0;
        if (duty_wr)                    m_dty = duty_data;
        else if (upd_wr && m_tgt == 0)  m_dty = upd_data;
        if (period_wr)                  m_prd = period_data;
        else if (upd_wr && m_tgt == 1)  m_prd = upd_data;
      end
      if (dis_req)     m_run = 0;
      else if (en_req) m_run = 1;
      if (cfg_wr) begin
        m_pol = cfg_invert;
        m_pre = (cfg_prescale > 10) ? 10 : cfg_prescale;
        m_tgt = cfg_upd_period;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks += 3;
      if (running !== (m_run != 0)) begin
        errors++; $display("FAIL R2 running act=%0d exp=%0d", running, m_run);
      end
      if (pwm_out !== m_out[0]) begin
        errors++; $display("FAIL R5 pwm_out act=%0d exp=%0d", pwm_out, m_out);
      end
      if (period_done !== m_done[0]) begin
        errors++; $display("FAIL R10 period_done act=%0d exp=%0d", period_done, m_done);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int pre, input int inv, input int tgt);
    cfg_prescale = pre[3:0]; cfg_invert = inv[0]; cfg_upd_period = tgt[0];
    cfg_wr = 1; cyc(1); cfg_wr = 0;
  endtask

  task automatic wr_duty(input int v);
    duty_data = v[15:0]; duty_wr = 1; cyc(1); duty_wr = 0;
  endtask

  task automatic wr_period(input int v);
    period_data = v[15:0]; period_wr = 1; cyc(1); period_wr = 0;
  endtask

  task automatic wr_upd(input int v);
    upd_data = v[15:0]; upd_wr = 1; cyc(1); upd_wr = 0;
  endtask

  task automatic start();
    en_req = 1; cyc(1); en_req = 0;
  endtask

  task automatic stop();
    dis_req = 1; cyc(1); dis_req = 0;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin cyc(1); h += pwm_out; end
  endtask

  task automatic count_done(input int n, output int d);
    d = 0;
    repeat (n) begin cyc(1); d += period_done; end
  endtask

  int v;

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    chk("R1 running after reset", running, 0);
    chk("R1 pwm_out after reset", pwm_out, 0);
    chk("R1 period_done after reset", period_done, 0);

    // R7: direct loads while stopped, then R5 high time.
    set_cfg(0, 0, 0);
    wr_period(10);
    wr_duty(4);
    start();
    cyc(3);
    count_high(10, v); chk("R5 high time duty4 period10", v, 6);
    count_done(30, v); chk("R4 wraps in 30 clocks", v, 3);

    // R8: direct writes ignored while running.
    wr_duty(1);
    wr_period(3);
    cyc(12);
    count_high(10, v); chk("R8 direct write ignored", v, 6);

    // R9: buffered duty update.
    wr_upd(8);
    cyc(12);
    count_high(10, v); chk("R9 buffered duty applied", v, 2);

    // R9 with period target; duty 8 over period 5 is full-off (R5).
    set_cfg(0, 0, 1);
    wr_upd(5);
    cyc(12);
    count_high(10, v); chk("R5 full-off when duty above period", v, 0);
    count_done(10, v); chk("R9 buffered period applied", v, 2);

    // R6: inversion, then stopped level.
    set_cfg(0, 1, 1);
    cyc(2);
    count_high(10, v); chk("R6 inverted output", v, 10);
    stop();
    cyc(2);
    chk("R2 stopped", running, 0);
    chk("R6 stopped level equals polarity", pwm_out, 1);

    // R7: buffered port loads period directly while stopped; R5 full-on.
    set_cfg(0, 0, 1);
    cyc(1);
    chk("R6 stopped level normal polarity", pwm_out, 0);
    wr_upd(6);
    wr_duty(0);
    start();
    cyc(3);
    count_high(12, v); chk("R7 full-on after direct loads", v, 12);
    count_done(12, v); chk("R7 period loaded through update port", v, 2);

    // R4: period 0 wraps on every tick.
    stop();
    wr_period(0);
    start();
    cyc(3);
    count_done(8, v); chk("R4 period zero wraps each tick", v, 8);

    // R11: pending update dropped on stop.
    stop();
    set_cfg(0, 0, 0);
    wr_period(10);
    wr_duty(3);
    start();
    cyc(3);
    upd_data = 16'd9; upd_wr = 1; dis_req = 1; cyc(1); upd_wr = 0; dis_req = 0;
    cyc(1);
    chk("R11 stopped by dis_req", running, 0);
    start();
    cyc(25);
    count_high(10, v); chk("R11 pending update discarded", v, 7);

    // R2: simultaneous start and stop while stopped.
    stop();
    en_req = 1; dis_req = 1; cyc(1); en_req = 0; dis_req = 0;
    cyc(1);
    chk("R2 stop wins over start", running, 0);

    // R3: prescaler.
    set_cfg(2, 0, 0);
    wr_period(4);
    wr_duty(0);
    start();
    cyc(3);
    count_done(64, v); chk("R3 prescale 2", v, 4);
    stop();
    set_cfg(15, 0, 0);
    wr_period(2);
    start();
    cyc(3);
    count_done(4096, v); chk("R3 prescale 15 clamps to 10", v, 2);
    stop();
    cyc(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule